// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural integer registers of a small 32-bit processor core. Sixteen registers are visible at any moment. Index 13 serves as stack pointer, index 14 as link register and index 15 as program counter. A separate current-status register sits beside them. Several of the visible indices are backed by different physical storage depending on the operating mode that the core presents on a 5-bit mode input. This lets an exception handler work on its own stack and return address without saving the interrupted code's copies first.

The fast-interrupt mode owns private copies of indices 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each own private copies of indices 13 and 14 only. User and system modes share one set. Each of the five exception modes also has one saved-status register, reached through a dedicated port that follows the current mode.

The block has two combinational read ports, one clocked write port, a status-register port and a saved-status port. The block never changes mode by itself: the mode input comes from the surrounding core. Physical storage amounts to 37 words: 31 general words, one current status word and five saved status words.

Top module: `bankreg_top`

## Requirements
- R1: While `rstN` is low, and after its release until the first write, every general register reads zero and the saved-status port reads zero. The status register reads 32'h0000_0013, which is the supervisor mode code in bits 4:0 with all other bits clear.
- R2: Mode codes on `modeIn` are: 5'b10000 user, 5'b10001 fast interrupt, 5'b10010 normal interrupt, 5'b10011 supervisor, 5'b10111 abort, 5'b11011 undefined, 5'b11111 system. Any other code selects the user register view and has no saved-status register.
- R3: Indices 0 to 7 and index 15 name the same physical word in every mode.
- R4: In fast-interrupt mode, indices 8 to 14 name words private to that mode. Writes there are not visible in any other mode, and writes made in other modes to those indices are not visible in fast-interrupt mode.
- R5: Normal-interrupt, supervisor, abort and undefined modes each have private words for indices 13 and 14. They share indices 8 to 12 with user mode.
- R6: System mode reads and writes exactly the user-mode words.
- R7: Each of the five exception modes has its own saved-status word. `savedWrEn` writes the word of the current mode, and `savedRd` shows that word.
- R8: In user mode, system mode or an unrecognised mode, `savedRd` is zero and `savedWrEn` changes no saved-status word.
- R9: A read port addressing the word being written in the same cycle returns the old value. The new value appears from the following cycle. Both read ports work independently.
- R10: `statusWrEn` loads `statusWrData` into the status register at the clock edge. Without it, the status register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeIn | input | 5 | Current operating mode code |
| rdAddrA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdAddrB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | General register write enable |
| wrAddr | input | 4 | General register write index |
| wrData | input | 32 | General register write data |
| statusWrEn | input | 1 | Status register write enable |
| statusWrData | input | 32 | Status register write data |
| statusRd | output | 32 | Status register value |
| savedWrEn | input | 1 | Saved-status write enable for the current mode |
| savedWrData | input | 32 | Saved-status write data |
| savedRd | output | 32 | Saved-status value of the current mode |

## Verification
Each mode is used in turn to fill its own view with distinct values. Every other mode then reads all sixteen indices. Values that leak across banks, or banks that are missing, are told apart from correctly shared words in this way. Writes with a read port on the same index show whether the old value is kept for one cycle. Unrecognised mode codes and saved-status writes in the unprivileged modes separate a fall-back to the user view from aliasing onto an exception bank. A long stretch of random modes, indices and enables is compared with the reference on every cycle and catches index arithmetic errors that the directed walks miss.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int NUM_PHYS   = 31;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int NUM_SAVED  = 5;
  localparam int SAVED_W    = $clog2(NUM_SAVED);
  localparam int MODE_W     = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // Physical layout: 0..15 shared view, 16..22 fast-interrupt 8..14,
  // then pairs (13,14) for normal-interrupt, supervisor, abort, undefined.
  localparam int FIQ_BASE  = 16;
  localparam int PAIR_BASE = 23;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  typedef struct packed {
    logic              gprWe;
    logic [PHYS_W-1:0] gprWrIdx;
    logic [PHYS_W-1:0] gprRdIdxA;
    logic [PHYS_W-1:0] gprRdIdxB;
    logic              statusWe;
    logic              savedWe;
    logic              savedValid;
    logic [SAVED_W-1:0] savedIdx;
  } strobe_t;

  function automatic bank_e decodeMode(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] modeIn,
  input  logic [3:0]        rdAddrA,
  input  logic [3:0]        rdAddrB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic              statusWrEn,
  input  logic              savedWrEn,
  output strobe_t           strobe
);

  bank_e curBank;

  function automatic logic [PHYS_W-1:0] physIdx(input bank_e bk, input logic [3:0] a);
    logic [PHYS_W-1:0] idx;
    idx = {1'b0, a};
    if (bk == BK_FIQ && a >= 4'd8 && a <= 4'd14) begin
      idx = PHYS_W'(FIQ_BASE) + PHYS_W'(a - 4'd8);
    end else if (bk != BK_USR && bk != BK_FIQ && (a == 4'd13 || a == 4'd14)) begin
      idx = PHYS_W'(PAIR_BASE) + PHYS_W'({(3'(bk) - 3'd2), 1'b0}) + PHYS_W'(a - 4'd13);
    end
    return idx;
  endfunction

  always_comb begin
    curBank           = decodeMode(modeIn);
    strobe.gprWe      = wrEn;
    strobe.gprWrIdx   = physIdx(curBank, wrAddr);
    strobe.gprRdIdxA  = physIdx(curBank, rdAddrA);
    strobe.gprRdIdxB  = physIdx(curBank, rdAddrB);
    strobe.statusWe   = statusWrEn;
    strobe.savedValid = (curBank != BK_USR);
    strobe.savedIdx   = SAVED_W'(3'(curBank) - 3'd1);
    strobe.savedWe    = savedWrEn && strobe.savedValid;
  end

endmodule

// File: rtl/bankreg_dp.sv
module bankreg_dp
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusWrData,
  input  logic [DATA_W-1:0] savedWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] statusRd,
  output logic [DATA_W-1:0] savedRd
);

  localparam logic [DATA_W-1:0] STATUS_RST = DATA_W'(MODE_SVC);

  logic [DATA_W-1:0] gprQ   [NUM_PHYS];
  logic [DATA_W-1:0] savedQ [NUM_SAVED];
  logic [DATA_W-1:0] statusQ;

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                           gprQ[g] <= '0;
      else if (strobe.gprWe && strobe.gprWrIdx == PHYS_W'(g)) gprQ[g] <= wrData;
    end
  end

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                             savedQ[s] <= '0;
      else if (strobe.savedWe && strobe.savedIdx == SAVED_W'(s)) savedQ[s] <= savedWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statusQ <= STATUS_RST;
    else if (strobe.statusWe) statusQ <= statusWrData;
  end

  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (strobe.gprRdIdxA == PHYS_W'(i)) rdDataA = gprQ[i];
      if (strobe.gprRdIdxB == PHYS_W'(i)) rdDataB = gprQ[i];
    end
  end

  always_comb begin
    savedRd = '0;
    for (int k = 0; k < NUM_SAVED; k++) begin
      if (strobe.savedValid && strobe.savedIdx == SAVED_W'(k)) savedRd = savedQ[k];
    end
  end

  assign statusRd = statusQ;

endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeIn,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] statusWrData,
  output logic [DATA_W-1:0] statusRd,
  input  logic              savedWrEn,
  input  logic [DATA_W-1:0] savedWrData,
  output logic [DATA_W-1:0] savedRd
);

  strobe_t strobe;

  bankreg_ctrl u_ctrl (
    .modeIn     (modeIn),
    .rdAddrA    (rdAddrA),
    .rdAddrB    (rdAddrB),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .statusWrEn (statusWrEn),
    .savedWrEn  (savedWrEn),
    .strobe     (strobe)
  );

  bankreg_dp #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .statusWrData (statusWrData),
    .savedWrData  (savedWrData),
    .rdDataA      (rdDataA),
    .rdDataB      (rdDataB),
    .statusRd     (statusRd),
    .savedRd      (savedRd)
  );

endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        modeIn,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic              statusWrEn,
  input logic [DATA_W-1:0] statusWrData,
  input logic [DATA_W-1:0] statusRd,
  input logic [DATA_W-1:0] savedRd,
  input strobe_t           strobe
);

  assert_unpriv_saved_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode(modeIn) == BK_USR) |-> (savedRd == '0));

  assert_unpriv_no_saved_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.savedWe |-> (decodeMode(modeIn) != BK_USR));

  assert_low_regs_shared_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr < 4'd8 || wrAddr == 4'd15)) |-> (strobe.gprWrIdx == PHYS_W'(wrAddr)));

  assert_fiq_private_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && modeIn == MODE_FIQ && wrAddr >= 4'd8 && wrAddr <= 4'd14)
      |-> (strobe.gprWrIdx >= PHYS_W'(FIQ_BASE) && strobe.gprWrIdx < PHYS_W'(PAIR_BASE)));

  assert_status_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |=> (statusRd == $past(statusWrData)));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !statusWrEn |=> $stable(statusRd));

endmodule

bind bankreg_top bankreg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bankreg_top_bench.sv
`timescale 1ns/1ps
module bankreg_top_bench;

  localparam int W = 32;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] modeIn = M_SVC;
  logic [3:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic wrEn = 1'b0, statusWrEn = 1'b0, savedWrEn = 1'b0;
  logic [W-1:0] wrData = '0, statusWrData = '0, savedWrData = '0;
  logic [W-1:0] rdDataA, rdDataB, statusRd, savedRd;

  always #2 clk = ~clk;

  bankreg_top u_bankreg_top (
    .clk(clk), .rstN(rstN), .modeIn(modeIn),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .statusRd(statusRd),
    .savedWrEn(savedWrEn), .savedWrData(savedWrData), .savedRd(savedRd)
  );

  // Reference model: keyed by (view, index) in plain arrays
  logic [W-1:0] mShared [16];
  logic [W-1:0] mFast   [7];
  logic [W-1:0] mPair   [4][2];
  logic [W-1:0] mSaved  [5];
  logic [W-1:0] mStatus;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;
  string curReq = "R1";

  // 0 user/system/unknown, 1 fast, 2 normal irq, 3 svc, 4 abort, 5 undef
  function automatic int viewOf(input logic [4:0] m);
    if (m == M_FIQ) return 1;
    if (m == M_IRQ) return 2;
    if (m == M_SVC) return 3;
    if (m == M_ABT) return 4;
    if (m == M_UND) return 5;
    return 0;
  endfunction

  function automatic logic [W-1:0] modelRead(input logic [4:0] m, input logic [3:0] a);
    int v;
    v = viewOf(m);
    if (v == 1 && a >= 8 && a <= 14) return mFast[a - 8];
    if (v >= 2 && (a == 13 || a == 14)) return mPair[v - 2][a - 13];
    return mShared[a];
  endfunction

  function automatic logic [W-1:0] modelSaved(input logic [4:0] m);
    int v;
    v = viewOf(m);
    if (v == 0) return '0;
    return mSaved[v - 1];
  endfunction

  task automatic modelWrite(input logic [4:0] m, input logic [3:0] a, input logic [W-1:0] d);
    int v;
    v = viewOf(m);
    if (v == 1 && a >= 8 && a <= 14) mFast[a - 8] = d;
    else if (v >= 2 && (a == 13 || a == 14)) mPair[v - 2][a - 13] = d;
    else mShared[a] = d;
  endtask

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mShared[i] = '0;
    for (int i = 0; i < 7; i++) mFast[i] = '0;
    for (int i = 0; i < 4; i++) begin mPair[i][0] = '0; mPair[i][1] = '0; end
    for (int i = 0; i < 5; i++) mSaved[i] = '0;
    mStatus = 32'h0000_0013;
  endtask

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s mode=%b: actual=%h expected=%h", curReq, what, modeIn, act, exp);
    end
  endtask

  // One clock: drive, compare outputs against model, advance model at the edge
  task automatic step(input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb,
                      input logic we, input logic [3:0] wa, input logic [W-1:0] wd,
                      input logic swe, input logic [W-1:0] swd,
                      input logic vwe, input logic [W-1:0] vwd);
    modeIn = m; rdAddrA = ra; rdAddrB = rb;
    wrEn = we; wrAddr = wa; wrData = wd;
    statusWrEn = swe; statusWrData = swd;
    savedWrEn = vwe; savedWrData = vwd;
    #1;
    chk("rdDataA", rdDataA, modelRead(m, ra));
    chk("rdDataB", rdDataB, modelRead(m, rb));
    chk("statusRd", statusRd, mStatus);
    chk("savedRd", savedRd, modelSaved(m));
    @(posedge clk);
    if (rstN) begin
      if (we) modelWrite(m, wa, wd);
      if (swe) mStatus = swd;
      if (vwe && viewOf(m) != 0) mSaved[viewOf(m) - 1] = vwd;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] a, input logic [W-1:0] d);
    step(m, a, a, 1'b1, a, d, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic sweep(input logic [4:0] m);
    for (int a = 0; a < 16; a += 2)
      step(m, 4'(a), 4'(a + 1), 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [7];
    modes = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
    modelReset();
    @(negedge clk);
    // R1: outputs during reset and right after release
    curReq = "R1";
    step(M_SVC, 4'd0, 4'd15, 1'b1, 4'd3, 32'hDEAD, 1'b0, '0, 1'b0, '0);
    rstN = 1'b1;
    sweep(M_SVC);
    sweep(M_FIQ);

    // R3: low indices and index 15 shared by every mode
    curReq = "R3";
    for (int a = 0; a < 8; a++) wr(M_USR, 4'(a), 32'h1000_0000 + a);
    wr(M_USR, 4'd15, 32'h1000_00FF);
    for (int i = 0; i < 7; i++) sweep(modes[i]);

    // R4: fast-interrupt private 8..14
    curReq = "R4";
    for (int a = 8; a < 15; a++) wr(M_USR, 4'(a), 32'h2000_0000 + a);
    for (int a = 8; a < 15; a++) wr(M_FIQ, 4'(a), 32'h2F00_0000 + a);
    sweep(M_USR); sweep(M_FIQ); sweep(M_IRQ);

    // R5: 13/14 private to irq, svc, abt, und; 8..12 shared
    curReq = "R5";
    for (int i = 2; i < 6; i++) begin
      wr(modes[i], 4'd13, 32'h3000_0000 + (i << 8));
      wr(modes[i], 4'd14, 32'h3000_0001 + (i << 8));
      wr(modes[i], 4'(6 + i), 32'h3500_0000 + i);
    end
    for (int i = 0; i < 7; i++) sweep(modes[i]);

    // R6: system equals user
    curReq = "R6";
    wr(M_SYS, 4'd13, 32'h6000_0013);
    wr(M_SYS, 4'd9, 32'h6000_0009);
    sweep(M_USR); sweep(M_SYS); sweep(M_FIQ);

    // R2: unrecognised codes select the user view
    curReq = "R2";
    wr(5'b00000, 4'd14, 32'h2200_000E);
    sweep(5'b10100); sweep(5'b00000); sweep(M_USR); sweep(M_UND);

    // R7: saved-status per exception mode
    curReq = "R7";
    for (int i = 1; i < 6; i++)
      step(modes[i], 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, 1'b1, 32'h7000_0000 + i);
    for (int i = 0; i < 7; i++)
      step(modes[i], 4'd2, 4'd3, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

    // R8: saved-status ignored in user, system, unknown
    curReq = "R8";
    step(M_USR, 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, 1'b1, 32'h8888_0001);
    step(M_SYS, 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, 1'b1, 32'h8888_0002);
    step(5'b01010, 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, 1'b1, 32'h8888_0003);
    for (int i = 0; i < 7; i++)
      step(modes[i], 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

    // R9: same-cycle read sees old value, next cycle new
    curReq = "R9";
    step(M_FIQ, 4'd10, 4'd10, 1'b1, 4'd10, 32'h9999_000A, 1'b0, '0, 1'b0, '0);
    step(M_FIQ, 4'd10, 4'd3, 1'b1, 4'd3, 32'h9999_0003, 1'b0, '0, 1'b0, '0);
    step(M_FIQ, 4'd3, 4'd10, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

    // R10: status register load and hold
    curReq = "R10";
    step(M_USR, 4'd0, 4'd1, 1'b0, '0, '0, 1'b1, 32'hA5A5_0010, 1'b0, '0);
    step(M_USR, 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, 32'hFFFF_FFFF, 1'b0, '0);
    step(M_IRQ, 4'd0, 4'd1, 1'b0, '0, '0, 1'b1, 32'h0000_0092, 1'b0, '0);
    step(M_IRQ, 4'd0, 4'd1, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

    // Mixed random traffic, all requirements
    curReq = "R2/R3/R4/R5/R6/R7/R8/R9/R10";
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      m = ($urandom_range(0, 9) == 0) ? 5'($urandom) : modes[$urandom_range(0, 6)];
      step(m, 4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom,
           ($urandom_range(0, 7) == 0), $urandom, 1'($urandom), $urandom);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule